// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a small synchronous static memory whose bus can change direction on any clock without an idle cycle. Every enabled clock edge takes one command: start a read burst, start a write burst, continue the current burst, or deselect. Reads return data two enabled edges after their command. Writes take their data from the bus two enabled edges after their command. Because both sit at the same pipeline position, a read may follow a write, or a write a read, on consecutive cycles with the data bus busy every cycle.

The word is split into byte lanes. Each lane carries eight data bits plus one parity bit, and each lane has its own active-low write enable. A two-bit burst sequencer steps the two low address bits in either linear or interleaved order. A clock enable freezes the whole block. An output enable gates the read bus directly. A sleep input quiets the block after a two-cycle delay.

Top module: `zt_sram`

## Requirements
- R1: After reset the read bus is not driven (`rdata_drive` low, `rdata` zero), and the burst state is the deselected state.
- R2: A new command is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 with `adv`=0. Any other enable pattern with `adv`=0 is a deselect: nothing is written and no read data is driven for that command.
- R3: If `adv`=0 and the block is selected, `we_n`=1 starts a read and `we_n`=0 starts a write at `addr`. Read data is driven on the second enabled edge after the command edge. Write data is taken from `wdata` at the second enabled edge after the command edge. Reads and writes may alternate on every edge.
- R4: With `adv`=1 the previous command type (read, write or deselect) continues at the next burst address, and the chip enables and `we_n` are ignored. A continue that follows a deselect is itself a deselect.
- R5: The two low address bits of a burst step through base+k modulo 4 when `interleave`=0, and through base XOR k when `interleave`=1, for k = 0..3, repeating. The upper address bits stay fixed for the whole burst.
- R6: Lane i occupies bits [9i+8:9i] of the data word, and bit 9i+8 is its parity bit, which is stored and returned like data. On a write, lane i is stored only if `bw_n[i]`=0. If all `bw_n` bits are 1, the write is aborted and memory is unchanged.
- R7: On an edge where `cke_n`=1, every input except `sleep` is discarded, and the pipeline, burst state and read output hold their values.
- R8: `oe_n`=1 releases the read bus in the same cycle, without waiting for a clock.
- R9: Commands are ignored (treated as deselect) from the second edge after `sleep` is seen high, and the read bus is released for as long as the block is asleep. After `sleep` falls, commands are accepted again from the second edge on.
- R10: A read issued on the edge directly after a write to the same address returns the newly written lanes merged with the old contents of the masked lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Second active-low chip enable |
| adv | input | 1 | 1 = continue burst, 0 = new command |
| we_n | input | 1 | 0 = write, 1 = read for a new command |
| bw_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address of a new command |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request |
| oe_n | input | 1 | Active-low output enable |
| wdata | input | LANES*9 | Write data with parity bits |
| rdata | output | LANES*9 | Read data, zero when not driven |
| rdata_drive | output | 1 | Read bus is driven |

## Verification
The bench aims at the cases where pipeline alignment goes wrong. These are a write followed at once by a read of the same word, with partial masks (R10), and mixed read/write streams with no gaps. A design that took write data one edge early or late would store the neighbouring beat. A design that read before the write committed would return stale lanes. Bursts are run in both orders, with the chip enables toggled during continues and with a continue after a deselect. A wrong sequencer shows up as data from the wrong word, and a design that honoured enables mid-burst would drop beats. Stalls during bursts, write aborts, sleep windows with commands offered and output-enable toggles are also covered. In those cases a faulty design would advance state, change memory, or drive the bus when it should be silent.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // low two address bits of burst beat k from base b
    function automatic logic [1:0] burst_low(input logic [1:0] b,
                                             input logic [1:0] k,
                                             input logic       intl);
        return intl ? (b ^ k) : (b + k);
    endfunction

endpackage

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);
    logic [1:0] zz_d, zz_q;

    always_comb begin
        zz_d = {zz_q[0], sleep};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zz_q <= '0;
        else        zz_q <= zz_d;
    end

    assign asleep = zz_q[1];

    AST_SLEEP_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sleep) |-> (zz_q[0] == 1'b1)) else $error("sleep stage"); // R9
endmodule

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              asleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              interleave,
    output op_e               iss_op,
    output logic [ADDR_W-1:0] iss_addr
);
    localparam int UP_W = ADDR_W - 2;

    typedef struct packed {
        op_e             last;
        logic [UP_W-1:0] upper;
        logic [1:0]      base;
        logic [1:0]      cnt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        iss_op   = OP_IDLE;
        iss_addr = addr;
        if (asleep) begin
            st_d.last = OP_IDLE;
        end else if (!adv) begin
            if (sel) begin
                st_d.last  = we_n ? OP_RD : OP_WR;
                st_d.upper = addr[ADDR_W-1:2];
                st_d.base  = addr[1:0];
                st_d.cnt   = 2'd0;
                iss_op     = st_d.last;
            end else begin
                st_d.last = OP_IDLE;
            end
        end else begin
            st_d.cnt = st_q.cnt + 2'd1;
            iss_op   = st_q.last;
            iss_addr = {st_q.upper, burst_low(st_q.base, st_d.cnt, interleave)};
        end
        if (!en) st_d = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: OP_IDLE, upper: '0, base: '0, cnt: '0};
        else        st_q <= st_d;
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && adv && !asleep |=> st_q.cnt == $past(st_q.cnt) + 2'd1) else $error("burst step"); // R4
    AST_CONT_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        en && adv |=> $stable(st_q.upper)) else $error("upper moved"); // R5
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int WORDS  = 64,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we_lane,
    input  logic [$clog2(WORDS)-1:0]  waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [$clog2(WORDS)-1:0]  raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (we_lane[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke_n,
    input  logic                        ce1_n,
    input  logic                        ce2,
    input  logic                        ce3_n,
    input  logic                        adv,
    input  logic                        we_n,
    input  logic [LANES-1:0]            bw_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        interleave,
    input  logic                        sleep,
    input  logic                        oe_n,
    input  logic [LANES*(BYTE_W+1)-1:0] wdata,
    output logic [LANES*(BYTE_W+1)-1:0] rdata,
    output logic                        rdata_drive
);
    localparam int LANE_W = BYTE_W + 1;
    localparam int DW     = LANES * LANE_W;
    localparam int WORDS  = 1 << ADDR_W;

    typedef struct packed {
        op_e              op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw_n;
    } stage_t;

    typedef struct packed {
        stage_t          s1;
        stage_t          s2;
        logic [DW-1:0]   dout;
        logic            dvld;
    } pipe_t;

    pipe_t             p_d, p_q;
    logic              en, asleep, sel;
    op_e               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  we_lane;
    logic [DW-1:0]     arr_rdata;

    assign en  = !cke_n;
    assign sel = !ce1_n && ce2 && !ce3_n;

    zt_sleep_ctl u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .asleep (asleep)
    );

    zt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .asleep     (asleep),
        .sel        (sel),
        .adv        (adv),
        .we_n       (we_n),
        .addr       (addr),
        .interleave (interleave),
        .iss_op     (iss_op),
        .iss_addr   (iss_addr)
    );

    assign we_lane = (en && p_q.s2.op == OP_WR) ? ~p_q.s2.bw_n : '0;

    zt_lane_array #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we_lane (we_lane),
        .waddr   (p_q.s2.addr),
        .wdata   (wdata),
        .raddr   (p_q.s2.addr),
        .rdata   (arr_rdata)
    );

    always_comb begin
        p_d = p_q;
        if (en) begin
            p_d.s1.op   = iss_op;
            p_d.s1.addr = iss_addr;
            p_d.s1.bw_n = bw_n;
            p_d.s2      = p_q.s1;
            p_d.dvld    = (p_q.s2.op == OP_RD);
            if (p_q.s2.op == OP_RD) p_d.dout = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.s1   <= '{op: OP_IDLE, addr: '0, bw_n: '1};
            p_q.s2   <= '{op: OP_IDLE, addr: '0, bw_n: '1};
            p_q.dout <= '0;
            p_q.dvld <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rdata_drive = p_q.dvld && !oe_n && !asleep;
    assign rdata       = rdata_drive ? p_q.dout : '0;

    AST_DESELECT_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        en && !adv && !asleep && !sel |=> p_q.s1.op == OP_IDLE) else $error("deselect issued"); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(p_q.s2) && $stable(p_q.dout) && $stable(p_q.dvld)) else $error("stall moved"); // R7
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_drive) else $error("driven with oe_n high"); // R8
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) && $past(sleep, 2) |-> !rdata_drive) else $error("driven asleep"); // R9
    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.s2.bw_n == '1 |-> we_lane == '0) else $error("abort wrote"); // R6
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
    localparam int AW = 6;
    localparam int L  = 2;
    localparam int DW = L * 9;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic adv = 1'b0, we_n = 1'b1, intl = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic [L-1:0]  bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    always #2.5 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(L), .BYTE_W(8)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .interleave(intl), .sleep(sleep), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    // reference model: 0 idle, 1 read, 2 write
    typedef struct {int op; int a; logic [L-1:0] b;} ent_t;
    ent_t pq[$];
    logic [DW-1:0] mem_m [NW];
    int m_last = 0, m_up = 0, m_base = 0, m_cnt = 0;
    bit z0 = 0, z1 = 0, m_vld = 0;
    logic [DW-1:0] m_out = '0;

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        ent_t ne, old;
        if (!cke_n) begin
            ne.op = 0; ne.a = addr; ne.b = bw_n;
            if (z1) m_last = 0;
            else if (!adv) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    m_last = we_n ? 1 : 2;
                    m_up = addr >> 2; m_base = addr & 3; m_cnt = 0;
                    ne.op = m_last; ne.a = addr;
                end else m_last = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 4;
                ne.op = m_last;
                ne.a = m_up * 4 + (intl ? (m_base ^ m_cnt) : ((m_base + m_cnt) % 4));
            end
            old = pq.pop_front();
            if (old.op == 2)
                for (int i = 0; i < L; i++)
                    if (!old.b[i]) mem_m[old.a][i*9 +: 9] = wdata[i*9 +: 9];
            m_vld = (old.op == 1);
            if (old.op == 1) m_out = mem_m[old.a];
            pq.push_back(ne);
        end
        z1 = z0; z0 = sleep;
    endtask

    task automatic tick();
        bit ed;
        wdata = DW'($urandom);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ed = m_vld && !oe_n && !z1;
        check("drive", 32'(rdata_drive), 32'(ed));
        check("rdata", 32'(rdata), ed ? 32'(m_out) : 32'd0);
    endtask

    task automatic new_op(bit wr, int a, logic [L-1:0] b);
        ce1_n = 0; ce2 = 1; ce3_n = 0; adv = 0; we_n = !wr; addr = AW'(a); bw_n = b;
        tick();
    endtask

    task automatic cont(logic [L-1:0] b);
        adv = 1; ce1_n = 1'($urandom); ce2 = 1'($urandom); ce3_n = 1'($urandom);
        we_n = 1'($urandom); addr = AW'($urandom); bw_n = b;
        tick();
    endtask

    task automatic desel(int k);
        adv = 0; we_n = 1'($urandom); bw_n = L'($urandom);
        case (k % 3)
            0: begin ce1_n = 1; ce2 = 1; ce3_n = 0; end
            1: begin ce1_n = 0; ce2 = 0; ce3_n = 0; end
            default: begin ce1_n = 0; ce2 = 1; ce3_n = 1; end
        endcase
        tick();
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) desel(i);
    endtask

    initial begin
        ent_t idle;
        idle.op = 0; idle.a = 0; idle.b = '1;
        pq.push_back(idle); pq.push_back(idle);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check("drive after reset", 32'(rdata_drive), 32'd0);
        check("rdata after reset", 32'(rdata), 32'd0);
        desel(0);

        tag = "R6";  // prefill, full lane writes
        for (int a = 0; a < NW; a++) new_op(1, a, '0);
        flush();

        tag = "R3";  // alternate read/write every edge
        for (int a = 0; a < 16; a++) new_op(a % 2 == 0, a, '0);
        for (int a = 0; a < 16; a++) new_op(a % 2 == 1, a, '0);
        flush();

        tag = "R10"; // write then immediate read, masked lanes
        for (int a = 20; a < 26; a++) begin
            new_op(1, a, L'(a % 3));
            new_op(0, a, '1);
        end
        flush();

        tag = "R5";
        for (int m = 0; m < 2; m++) begin
            intl = 1'(m);
            for (int bs = 0; bs < 4; bs++) begin
                new_op(0, 8 + bs, '1);
                repeat (5) cont('1);
            end
            flush();
        end
        intl = 0;

        tag = "R4";  // write burst with noisy enables, then continue after deselect
        new_op(1, 33, '0);
        repeat (3) cont('0);
        desel(1);
        repeat (3) cont('0);
        new_op(0, 32, '1);
        repeat (3) cont('1);
        flush();

        tag = "R2";
        for (int k = 0; k < 6; k++) begin
            desel(k);
            new_op(0, 40 + k, '1);
        end
        flush();

        tag = "R6";  // per-lane writes and aborts
        new_op(1, 50, 2'b10); new_op(1, 51, 2'b01); new_op(1, 52, 2'b11);
        new_op(0, 50, '1); new_op(0, 51, '1); new_op(0, 52, '1);
        flush();

        tag = "R7";
        new_op(0, 4, '1);
        cke_n = 1; repeat (3) tick(); cke_n = 0;
        cont('1);
        new_op(1, 4, '0);
        cke_n = 1; tick(); cke_n = 0;
        cont('0);
        cke_n = 1; tick(); cke_n = 0;
        new_op(0, 4, '1); cont('1);
        flush();

        tag = "R8";
        new_op(0, 12, '1); repeat (3) cont('1);
        oe_n = 1; tick(); tick(); oe_n = 0;
        flush();

        tag = "R9";
        new_op(0, 16, '1);
        sleep = 1;
        repeat (3) cont('1);
        for (int a = 0; a < 4; a++) new_op(1, 16 + a, '0);
        sleep = 0;
        new_op(1, 60, '0);
        new_op(1, 61, '0);
        new_op(0, 60, '1);
        for (int a = 0; a < 4; a++) new_op(0, 16 + a, '1);
        flush();

        tag = "R3";  // random mix
        for (int n = 0; n < 4000; n++) begin
            int c;
            if (n == 2000) intl = 1;
            cke_n = ($urandom % 100) < 8;
            oe_n  = ($urandom % 10) == 0;
            c = $urandom % 10;
            if (c < 5) new_op(1'($urandom), $urandom % NW,
                              ($urandom % 4 == 0) ? '1 : L'($urandom));
            else if (c < 8) cont(L'($urandom));
            else desel($urandom % 3);
        end
        cke_n = 0; oe_n = 0;
        flush();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule